// File: doc/BRIEF.md
# Burst Bus Initiator with Device-Select Timeout

This block is the initiator side of a 32-bit multiplexed address/data bus of the PCI kind. A local client hands it one burst request: a direction, a start address and a beat count. The block raises a bus request and waits for the grant. It then drives an address phase carrying a command code, followed by data phases, until every beat is moved or the target ends the transfer. Write data is pulled from the client one beat at a time through a beat index. Read data is passed back one cycle after each completed beat, with a flag that marks a parity mismatch.

If no target claims the cycle within five data cycles, the block ends the transfer by itself (master abort). It classifies a stop from the target into one of three cases: disconnect with data, retry, or target abort. After a retry the block reports the retry, requests the bus again, and resumes at the first beat that had not completed. Every tenure ends with a one-cycle completion pulse that carries a status code and the cumulative number of completed beats. All bus signals are active-high logical values; pin polarity and tristate control are left to the pad logic.

Top module: `pciInitiator`

## Requirements
- R1: `reqReady` is high only while the block is idle with frame and initiator-ready low. After a request is accepted, `busReq` rises. An address phase (frame high, initiator-ready low) occurs only in the cycle after a clock edge at which `busGnt` was high.
- R2: In the address phase `adOut` carries the current address and `cbeOut` carries the command: 4'b0111 for a write, 4'b0110 for a read. In every data phase `cbeOut` is 4'b0000.
- R3: During data phases `frameOut` stays high while more than one beat remains and is low in the final data phase.
- R4: A beat completes only at a clock edge where `irdyOut`, `trdyIn` and `devselIn` are all high. A write beat drives `wrData`, which the client supplies for the current `beatIdx`. A completed read beat appears on `rdData` with `rdValid` high in the next cycle.
- R5: In the cycle after a tenure ends, `frameOut` and `irdyOut` are both low and `doneValid` pulses for one cycle with `doneStatus` and `doneBeats`.
- R6: If `devselIn` is not sampled high in any of the first five data cycles, the tenure ends after the fifth with status 4 (master abort). If `devselIn` arrives in the fifth data cycle, there is no abort.
- R7: `stopIn` with `devselIn` and `trdyIn` high completes that beat and ends the request with status 1 (disconnect).
- R8: `stopIn` with `devselIn` high and `trdyIn` low ends the tenure with status 2 (retry). The block then requests the bus again and restarts at address base + 4 × completed beats, with the beat index continuing.
- R9: `stopIn` with `devselIn` low ends the request with status 3 (target abort) and completes no beat.
- R10: Whenever `frameOut` or `irdyOut` is high, `parOut` gives even parity over `adOut` and `cbeOut`.
- R11: For each completed read beat, `rdParErr` is high exactly when `parIn` differs from the XOR of `adIn` and `cbeOut` at that edge.
- R12: A request of N beats (1 ≤ N ≤ 15) that meets no stop or timeout ends with status 0 and `doneBeats` = N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Client presents a burst request |
| reqReady | output | 1 | Block is idle and takes the request |
| reqWrite | input | 1 | 1 = write burst, 0 = read burst |
| reqAddr | input | 32 | Start byte address |
| reqLen | input | 4 | Number of beats, 1 to 15 |
| beatIdx | output | 4 | Index of the beat now on the bus |
| wrData | input | 32 | Write data for `beatIdx` |
| rdValid | output | 1 | Read beat available |
| rdData | output | 32 | Read data |
| rdParErr | output | 1 | Parity mismatch on this read beat |
| doneValid | output | 1 | Tenure finished |
| doneStatus | output | 3 | 0 ok, 1 disconnect, 2 retry, 3 target abort, 4 master abort |
| doneBeats | output | 4 | Beats completed so far for this request |
| busReq | output | 1 | Bus request to the arbiter |
| busGnt | input | 1 | Bus grant |
| frameOut | output | 1 | Frame |
| irdyOut | output | 1 | Initiator ready |
| devselIn | input | 1 | Device select from target |
| trdyIn | input | 1 | Target ready |
| stopIn | input | 1 | Target stop |
| adOut | output | 32 | Address/data driven by the block |
| adIn | input | 32 | Address/data from the bus |
| cbeOut | output | 4 | Command / byte enables |
| parOut | output | 1 | Even parity over `adOut` and `cbeOut` |
| parIn | input | 1 | Parity from the bus for read data |

## Verification
The bench targets the timeout boundary. A target that claims the cycle in the fifth data cycle must complete normally, and one that never claims it must be aborted after exactly five cycles. An off-by-one counter would therefore abort a valid target or hang a missing one. Retries are injected in the middle of bursts, and each beat's address and data are checked after the restart. A design that restarted from the start address, or that skipped the beat that was refused, would drive a wrong address or a wrong data word. Stops are also applied on the first and the last beat in each of their three forms. This catches a design that mixes up disconnect and retry, or that counts the refused beat as completed. Randomized wait states and single-beat bursts check that frame drops exactly in the final data phase and that initiator-ready is released in the next cycle.

// File: rtl/pciInitPkg.sv
package pciInitPkg;

  typedef enum logic [2:0] {
    ST_OK     = 3'd0,
    ST_DISC   = 3'd1,
    ST_RETRY  = 3'd2,
    ST_TABORT = 3'd3,
    ST_MABORT = 3'd4
  } doneStatus_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;       // latch a new local request
    logic addrPhase;  // address phase is on the bus
    logic dataPhase;  // a data phase is on the bus
    logic waitTick;   // one more data cycle without device select
    logic markSeen;   // device select observed in this tenure
    logic beatDone;   // current beat completes at this edge
  } ctrlStrobe_t;

endpackage

// File: rtl/pciInitDpath.sv
module pciInitDpath
  import pciInitPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 4,
  parameter int TIMEOUT_CYC = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic                reqWrite,
  input  logic [DATA_W-1:0]   reqAddr,
  input  logic [LEN_W-1:0]    reqLen,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [DATA_W-1:0]   adIn,
  input  logic                parIn,
  output logic [DATA_W-1:0]   adOut,
  output logic [DATA_W/8-1:0] cbeOut,
  output logic                parOut,
  output logic [LEN_W-1:0]    beatIdx,
  output logic                lastBeat,
  output logic                waitExpired,
  output logic                seenQ,
  output logic                rdValid,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdParErr
);

  localparam int BE_W   = DATA_W / 8;
  localparam int WAIT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [BE_W-1:0] CMD_WR = BE_W'(4'b0111);
  localparam logic [BE_W-1:0] CMD_RD = BE_W'(4'b0110);

  logic [DATA_W-1:0] curAddr;
  logic [LEN_W-1:0]  remain;
  logic [LEN_W-1:0]  beatCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic              isWrite;
  logic              rdBeat;

  assign rdBeat = strb.beatDone && !isWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      remain  <= '0;
      beatCnt <= '0;
      waitCnt <= '0;
      seenQ   <= 1'b0;
      isWrite <= 1'b0;
    end else begin
      if (strb.load) begin
        curAddr <= reqAddr;
        remain  <= reqLen;
        beatCnt <= '0;
        isWrite <= reqWrite;
      end
      if (strb.addrPhase) begin
        waitCnt <= '0;
        seenQ   <= 1'b0;
      end
      if (strb.waitTick) waitCnt <= waitCnt + 1'b1;
      if (strb.markSeen) seenQ <= 1'b1;
      if (strb.beatDone) begin
        curAddr <= curAddr + DATA_W'(BE_W);
        remain  <= remain - 1'b1;
        beatCnt <= beatCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      rdData   <= '0;
      rdParErr <= 1'b0;
    end else begin
      rdValid  <= rdBeat;
      rdParErr <= rdBeat && (parIn != (^{adIn, cbeOut}));
      if (rdBeat) rdData <= adIn;
    end
  end

  always_comb begin
    adOut  = '0;
    cbeOut = '0;
    if (strb.addrPhase) begin
      adOut  = curAddr;
      cbeOut = isWrite ? CMD_WR : CMD_RD;
    end else if (strb.dataPhase && isWrite) begin
      adOut = wrData;
    end
  end

  assign parOut      = ^{adOut, cbeOut};
  assign beatIdx     = beatCnt;
  assign lastBeat    = (remain == LEN_W'(1));
  assign waitExpired = (waitCnt == WAIT_W'(TIMEOUT_CYC - 1));

endmodule

// File: rtl/pciInitCtrl.sv
module pciInitCtrl
  import pciInitPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        busGnt,
  input  logic        devselIn,
  input  logic        trdyIn,
  input  logic        stopIn,
  input  logic        lastBeat,
  input  logic        waitExpired,
  input  logic        seenQ,
  output ctrlStrobe_t strb,
  output logic        reqReady,
  output logic        busReq,
  output logic        frameOut,
  output logic        irdyOut,
  output logic        doneValid,
  output logic [2:0]  doneStatus
);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_ADDR, S_DATA, S_END} state_t;

  state_t      state, nextState;
  doneStatus_t statusQ, nextStatus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      statusQ <= ST_OK;
    end else begin
      state   <= nextState;
      statusQ <= nextStatus;
    end
  end

  always_comb begin
    nextState  = state;
    nextStatus = statusQ;
    strb       = '0;
    case (state)
      S_IDLE: if (reqValid) begin
        strb.load = 1'b1;
        nextState = S_REQ;
      end
      S_REQ: if (busGnt) nextState = S_ADDR;
      S_ADDR: begin
        strb.addrPhase = 1'b1;
        nextState      = S_DATA;
      end
      S_DATA: begin
        strb.dataPhase = 1'b1;
        strb.waitTick  = !devselIn && !seenQ;
        strb.markSeen  = devselIn;
        if (stopIn) begin
          nextState = S_END;
          if (devselIn && trdyIn) begin
            strb.beatDone = 1'b1;
            nextStatus    = ST_DISC;
          end else if (devselIn) begin
            nextStatus = ST_RETRY;
          end else begin
            nextStatus = ST_TABORT;
          end
        end else if (devselIn && trdyIn) begin
          strb.beatDone = 1'b1;
          if (lastBeat) begin
            nextState  = S_END;
            nextStatus = ST_OK;
          end
        end else if (!devselIn && !seenQ && waitExpired) begin
          nextState  = S_END;
          nextStatus = ST_MABORT;
        end
      end
      S_END: nextState = (statusQ == ST_RETRY) ? S_REQ : S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign reqReady   = (state == S_IDLE);
  assign busReq     = (state == S_REQ);
  assign irdyOut    = (state == S_DATA);
  assign frameOut   = (state == S_ADDR) || ((state == S_DATA) && !lastBeat);
  assign doneValid  = (state == S_END);
  assign doneStatus = statusQ;

endmodule

// File: rtl/pciInitiator.sv
module pciInitiator
  import pciInitPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 4,
  parameter int TIMEOUT_CYC = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [DATA_W-1:0]   reqAddr,
  input  logic [LEN_W-1:0]    reqLen,
  output logic [LEN_W-1:0]    beatIdx,
  input  logic [DATA_W-1:0]   wrData,
  output logic                rdValid,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdParErr,
  output logic                doneValid,
  output logic [2:0]          doneStatus,
  output logic [LEN_W-1:0]    doneBeats,
  output logic                busReq,
  input  logic                busGnt,
  output logic                frameOut,
  output logic                irdyOut,
  input  logic                devselIn,
  input  logic                trdyIn,
  input  logic                stopIn,
  output logic [DATA_W-1:0]   adOut,
  input  logic [DATA_W-1:0]   adIn,
  output logic [DATA_W/8-1:0] cbeOut,
  output logic                parOut,
  input  logic                parIn
);

  ctrlStrobe_t strb;
  logic        lastBeat;
  logic        waitExpired;
  logic        seenQ;

  pciInitCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .busGnt     (busGnt),
    .devselIn   (devselIn),
    .trdyIn     (trdyIn),
    .stopIn     (stopIn),
    .lastBeat   (lastBeat),
    .waitExpired(waitExpired),
    .seenQ      (seenQ),
    .strb       (strb),
    .reqReady   (reqReady),
    .busReq     (busReq),
    .frameOut   (frameOut),
    .irdyOut    (irdyOut),
    .doneValid  (doneValid),
    .doneStatus (doneStatus)
  );

  pciInitDpath #(
    .DATA_W     (DATA_W),
    .LEN_W      (LEN_W),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqLen     (reqLen),
    .wrData     (wrData),
    .adIn       (adIn),
    .parIn      (parIn),
    .adOut      (adOut),
    .cbeOut     (cbeOut),
    .parOut     (parOut),
    .beatIdx    (beatIdx),
    .lastBeat   (lastBeat),
    .waitExpired(waitExpired),
    .seenQ      (seenQ),
    .rdValid    (rdValid),
    .rdData     (rdData),
    .rdParErr   (rdParErr)
  );

  assign doneBeats = beatIdx;

endmodule

// File: rtl/pciInitChk.sv
module pciInitChk #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqReady,
  input logic                busGnt,
  input logic                frameOut,
  input logic                irdyOut,
  input logic                devselIn,
  input logic                trdyIn,
  input logic                stopIn,
  input logic                rdValid,
  input logic                doneValid,
  input logic [DATA_W-1:0]   adOut,
  input logic [DATA_W/8-1:0] cbeOut,
  input logic                parOut
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!frameOut && !irdyOut));

  // R1
  grant_before_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameOut && !irdyOut) |-> $past(busGnt));

  // R4
  read_after_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(irdyOut && trdyIn && devselIn));

  // R5
  final_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irdyOut && !frameOut && trdyIn && devselIn && !stopIn) |=> (!irdyOut && !frameOut && doneValid));

  // R5
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irdyOut && stopIn) |=> (!irdyOut && !frameOut && doneValid));

  // R10
  even_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameOut || irdyOut) |-> ($countones({adOut, cbeOut, parOut}) % 2 == 0));

endmodule

bind pciInitiator pciInitChk #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .busGnt   (busGnt),
  .frameOut (frameOut),
  .irdyOut  (irdyOut),
  .devselIn (devselIn),
  .trdyIn   (trdyIn),
  .stopIn   (stopIn),
  .rdValid  (rdValid),
  .doneValid(doneValid),
  .adOut    (adOut),
  .cbeOut   (cbeOut),
  .parOut   (parOut)
);

// File: tb/pciInitiator_tb_top.sv
module pciInitiator_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [3:0]  reqLen = '0;
  logic [3:0]  beatIdx;
  logic [31:0] wrData;
  logic        rdValid;
  logic [31:0] rdData;
  logic        rdParErr;
  logic        doneValid;
  logic [2:0]  doneStatus;
  logic [3:0]  doneBeats;
  logic        busReq;
  logic        busGnt = 1'b0;
  logic        frameOut, irdyOut;
  logic        devselIn = 1'b0, trdyIn = 1'b0, stopIn = 1'b0;
  logic [31:0] adOut;
  logic [31:0] adIn = '0;
  logic [3:0]  cbeOut;
  logic        parOut;
  logic        parIn = 1'b0;

  always #10 clk = ~clk;

  pciInitiator dut_i (.*);

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // scenario
  bit          sWrite;
  int          sLen, sDev, sStopAt, sMode, sBad, sGntDly;
  logic [31:0] sBase, sSeed;
  // target model state
  int  tgtBeat, cyc, lastCyc, rdIdx, gntCnt;
  bit  stopUsed, endPending, inTenure, seenDev;
  int  logN;
  int  logSt[0:7];
  int  logBt[0:7];

  function automatic logic [31:0] wrPat(int i);
    return sSeed ^ (32'(i) * 32'h9E3779B9);
  endfunction
  function automatic logic [31:0] rdPat(int i);
    return ~sSeed + (32'(i) * 32'h01000193);
  endfunction

  assign wrData = wrPat(int'(beatIdx));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog run did not finish actual=%0d expected=<150000", cycles);
        finishRun();
      end
    end
  end

  // bus target, arbiter and output monitor, all on the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (rdValid) begin
        check(rdData == rdPat(rdIdx), "R4", "read data", rdData, rdPat(rdIdx));
        check(rdParErr == (rdIdx == sBad), "R11", "read parity flag", rdParErr, (rdIdx == sBad));
        rdIdx++;
      end
      if (doneValid) begin
        if (logN < 8) begin
          logSt[logN] = int'(doneStatus);
          logBt[logN] = int'(doneBeats);
        end
        logN++;
        if (doneStatus == 3'd4)
          check(lastCyc == 5, "R6", "data cycles before master abort", lastCyc, 5);
      end
      if (endPending) begin
        check(!frameOut && !irdyOut && doneValid, "R5", "release after end",
              {frameOut, irdyOut, doneValid}, 3'b001);
        endPending = 1'b0;
      end
      // arbiter
      if (frameOut && !irdyOut)
        check(busGnt, "R1", "grant before address phase", busGnt, 1);
      if (busReq) begin
        gntCnt++;
        busGnt = (gntCnt > sGntDly);
      end else begin
        gntCnt = 0;
        busGnt = 1'b0;
      end
      // target
      devselIn = 1'b0; trdyIn = 1'b0; stopIn = 1'b0;
      if (frameOut && !irdyOut) begin
        check(adOut == sBase + 32'(4 * tgtBeat), "R8", "address phase address",
              adOut, sBase + 32'(4 * tgtBeat));
        check(cbeOut == (sWrite ? 4'b0111 : 4'b0110), "R2", "command code",
              cbeOut, sWrite ? 4'b0111 : 4'b0110);
        cyc = 0; seenDev = 1'b0; inTenure = 1'b1;
      end else if (irdyOut) begin
        cyc++;
        lastCyc = cyc;
        check(frameOut == (tgtBeat < sLen - 1), "R3", "frame vs remaining beats",
              frameOut, (tgtBeat < sLen - 1));
        check(cbeOut == 4'b0000, "R2", "data phase byte enables", cbeOut, 0);
        check(^{adOut, cbeOut, parOut} == 1'b0, "R10", "even parity", parOut, ^{adOut, cbeOut});
        if (cyc >= sDev) begin
          if (!stopUsed && tgtBeat == sStopAt) begin
            stopUsed = 1'b1;
            stopIn = 1'b1;
            devselIn = (sMode != 3);
            trdyIn = (sMode == 1);
            endPending = 1'b1;
          end else begin
            devselIn = 1'b1;
            trdyIn = ($urandom % 4) != 0;
          end
        end
        if (devselIn) seenDev = 1'b1;
        adIn = rdPat(tgtBeat);
        parIn = (^{rdPat(tgtBeat), 4'b0000}) ^ (tgtBeat == sBad);
        if (devselIn && trdyIn) begin
          if (sWrite)
            check(adOut == wrPat(tgtBeat), "R4", "write data", adOut, wrPat(tgtBeat));
          if (tgtBeat == sLen - 1) endPending = 1'b1;
          tgtBeat++;
        end
        if (!seenDev && cyc == 5 && !stopIn) endPending = 1'b1;
      end
    end
  end

  task automatic runTxn(input bit w, input int len, input int dev, input int stopAt,
                        input int mode, input int bad);
    int expBeats;
    sWrite = w; sLen = len; sDev = dev; sStopAt = stopAt; sMode = mode; sBad = bad;
    sGntDly = $urandom % 4;
    sBase = $urandom & 32'hFFFF_FFFC;
    sSeed = $urandom;
    tgtBeat = 0; rdIdx = 0; logN = 0; stopUsed = (mode == 0);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    check(!frameOut && !irdyOut, "R1", "idle with ready", {frameOut, irdyOut}, 0);
    reqWrite = w; reqAddr = sBase; reqLen = 4'(len); reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(busReq, "R1", "request raised after accept", busReq, 1);
    while (logN == 0 || (logN <= 8 && logSt[logN-1] == 2)) @(negedge clk);
    @(negedge clk);
    if (dev > 5) begin
      expBeats = 0;
      check(logN == 1 && logSt[0] == 4 && logBt[0] == 0, "R6", "master abort status",
            logSt[0], 4);
    end else if (mode == 1) begin
      expBeats = stopAt + 1;
      check(logN == 1 && logSt[0] == 1 && logBt[0] == stopAt + 1, "R7", "disconnect status",
            {logSt[0], logBt[0]}, {32'd1, 32'(stopAt + 1)});
    end else if (mode == 2) begin
      expBeats = len;
      check(logN == 2 && logSt[0] == 2 && logBt[0] == stopAt, "R8", "retry status",
            {logSt[0], logBt[0]}, {32'd2, 32'(stopAt)});
      check(logN == 2 && logSt[1] == 0 && logBt[1] == len, "R8", "completion after retry",
            {logSt[1], logBt[1]}, {32'd0, 32'(len)});
    end else if (mode == 3) begin
      expBeats = stopAt;
      check(logN == 1 && logSt[0] == 3 && logBt[0] == stopAt, "R9", "target abort status",
            {logSt[0], logBt[0]}, {32'd3, 32'(stopAt)});
    end else begin
      expBeats = len;
      check(logN == 1 && logSt[0] == 0 && logBt[0] == len, "R12", "normal completion",
            {logSt[0], logBt[0]}, {32'd0, 32'(len)});
    end
    check(tgtBeat == expBeats, "R4", "beats seen on bus", tgtBeat, expBeats);
    if (!w) check(rdIdx == expBeats, "R4", "read beats returned", rdIdx, expBeats);
  endtask

  initial begin
    void'($urandom(32'd4242));
    sLen = 1; sBad = -1; sDev = 1; stopUsed = 1'b1;
    repeat (3) @(negedge clk);
    check(reqReady && !busReq && !frameOut && !irdyOut && !doneValid && !rdValid,
          "R1", "reset state", {reqReady, busReq, frameOut, irdyOut, doneValid, rdValid}, 6'b100000);
    rstN = 1'b1;
    // directed corners
    runTxn(1, 1, 1, 0, 0, -1);    // R12 single beat write
    runTxn(0, 4, 5, 0, 0, -1);    // R6 devsel in fifth cycle, no abort
    runTxn(1, 3, 6, 0, 0, -1);    // R6 master abort
    runTxn(0, 2, 6, 0, 0, -1);    // R6 master abort on read
    runTxn(1, 8, 2, 3, 2, -1);    // R8 retry mid burst
    runTxn(0, 6, 1, 0, 2, -1);    // R8 retry on first beat
    runTxn(1, 5, 2, 4, 1, -1);    // R7 disconnect on last beat
    runTxn(0, 5, 3, 0, 3, -1);    // R9 target abort on first beat
    runTxn(0, 7, 1, 2, 0, 2);     // R11 bad parity on beat 2
    runTxn(1, 15, 1, 14, 2, -1);  // R8 retry at final beat of longest burst
    // random mix
    for (int n = 0; n < 60; n++) begin
      int len, dev, mode, stopAt, bad;
      len = 1 + ($urandom % 15);
      dev = ($urandom % 8 == 0) ? 6 : 1 + ($urandom % 5);
      mode = ($urandom % 2 == 0) ? 0 : 1 + ($urandom % 3);
      stopAt = $urandom % len;
      bad = ($urandom % 3 == 0) ? int'($urandom % len) : -1;
      runTxn(1'($urandom % 2), len, dev, stopAt, mode, bad);
    end
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule